// File: doc/BRIEF.md
# Protection and Operating-Mode Sequencer

This block is the supervisory state machine of an offline switching power controller. Comparator outputs reach it as clean, synchronous single-bit flags: supply alive, supply at its on level, input surge, brownout, overcurrent, feedback too high, feedback below the disable level, control pin low, control pin high, and end of soft-start. From these flags it decides whether the power switch may run. It also decides whether the high-voltage start-up charger feeds the supply, and whether the soft-start capacitor is held discharged.

There are two kinds of halt. A hold keeps everything biased, and the machine resumes straight into the state it left, with no new soft-start. A sleep is the low-power state. In sleep the charger is enabled and the soft-start capacitor is discharged. Sleep ends only through a new start-up and soft-start, which begins either after a timed recovery interval or when the control pin is released. A single millisecond counter, driven by an external tick, times every qualification, hold and recovery interval.

Top module: `psu_mode_seq`

## Requirements
- R1: Synchronous reset puts the machine in boot (mode code 0). In boot the charger is on, switching is off and the soft-start discharge is off.
- R2: Boot moves to soft-start (code 1) when the supply is alive, at its on level and the control pin is not low. Soft-start moves to run (code 2) on the end-of-soft-start flag. Switching is enabled in soft-start and run.
- R3: A supply that is not alive sends every state to boot on the next clock. This has the highest priority.
- R4: Overcurrent in soft-start or run drops the switch enable in the same cycle. On the next clock the machine enters the overcurrent hold (code 3). After OC_MS ticks, one more clock resumes switching.
- R5: A surge in soft-start or run enters the surge hold (code 4). If the surge clears before SURGE_MS ticks have elapsed, the machine resumes. Otherwise it enters fault sleep (code 6).
- R6: Feedback below the disable level enters the feedback hold (code 5). The machine stays there while the flag is set and resumes on the clock after it clears.
- R7: In run, if any of brownout, feedback-too-high or control-high stays present through QUAL_MS ticks, the machine enters fault sleep. A cycle with all three clear restarts the qualification.
- R8: In soft-start, brownout, feedback-too-high and control-high have no effect on the mode.
- R9: Fault sleep returns to boot once REC_MS ticks have elapsed, with surge and control-low both clear. A surge still present holds it in sleep.
- R10: Control-low in soft-start, run or any hold (with no surge) enters control sleep (code 7) on the next clock. Releasing it, with no surge, returns to boot.
- R11: The charger is enabled in boot and in both sleeps. The discharge is enabled in both sleeps only. Switching is never enabled outside soft-start and run.
- R12: In soft-start and run, coincident flags resolve in the order overcurrent, surge, control-low, feedback-low, then qualified faults.
- R13: A hold entered from soft-start resumes into soft-start. A hold entered from run resumes into run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| vcc_alive_i | input | 1 | Supply above its reset level |
| vcc_on_i | input | 1 | Supply at or above its on level |
| surge_i | input | 1 | Input voltage above surge level |
| brown_i | input | 1 | Brownout detected |
| oc_i | input | 1 | Switch current above overcurrent level |
| fb_high_i | input | 1 | Feedback above optocoupler-failure level |
| fb_low_i | input | 1 | Feedback below disable level |
| ctl_low_i | input | 1 | Control pin below disable level |
| ctl_high_i | input | 1 | Control pin above timed-disable level |
| ss_end_i | input | 1 | Soft-start capacitor at end level |
| sw_en_o | output | 1 | Switching enable |
| chg_en_o | output | 1 | Start-up charger enable |
| ss_dis_o | output | 1 | Soft-start capacitor discharge |
| mode_o | output | 3 | Mode code (0 boot, 1 soft, 2 run, 3 oc hold, 4 surge hold, 5 fb hold, 6 fault sleep, 7 control sleep) |

## Verification
The properties assume that every flag is already synchronous to the clock, and that each flag holds its value across the edge on which it is judged. They also assume that the tick is a single-cycle pulse. The stimulus changes flags only at the falling edge and raises the tick for exactly one cycle. It never places a tick on the edge where the mode changes, so every interval comes out at an exact, predictable count. Priority is exercised by sweeping all combinations of the five competing conditions from both switching states.

// File: rtl/psu_seq_pkg.sv
`timescale 1ns/1ps
package psu_seq_pkg;

    typedef enum logic [2:0] {
        M_BOOT       = 3'd0,
        M_SOFT       = 3'd1,
        M_RUN        = 3'd2,
        M_HOLD_OC    = 3'd3,
        M_HOLD_SURGE = 3'd4,
        M_HOLD_FB    = 3'd5,
        M_SLEEP_FLT  = 3'd6,
        M_SLEEP_CTL  = 3'd7
    } mode_e;

    typedef struct packed {
        logic alive;
        logic on;
        logic surge;
        logic brown;
        logic oc;
        logic fb_high;
        logic fb_low;
        logic ctl_low;
        logic ctl_high;
        logic ss_end;
    } flags_t;

    function automatic logic is_switching(input mode_e m);
        return (m == M_SOFT) || (m == M_RUN);
    endfunction

    function automatic logic is_hold(input mode_e m);
        return (m == M_HOLD_OC) || (m == M_HOLD_SURGE) || (m == M_HOLD_FB);
    endfunction

    function automatic logic is_sleep(input mode_e m);
        return (m == M_SLEEP_FLT) || (m == M_SLEEP_CTL);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer #(
    parameter int unsigned W   = 12,
    parameter int unsigned MAX = 2500
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] SAT = W'(MAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && tick && (cnt != SAT)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/seq_fsm.sv
`timescale 1ns/1ps
module seq_fsm
    import psu_seq_pkg::*;
#(
    parameter int unsigned W        = 12,
    parameter int unsigned OC_MS    = 1,
    parameter int unsigned SURGE_MS = 10,
    parameter int unsigned QUAL_MS  = 100,
    parameter int unsigned REC_MS   = 2500
) (
    input  logic         clk,
    input  logic         rst,
    input  flags_t       f,
    input  logic [W-1:0] cnt,
    output mode_e        mode,
    output logic         tmr_clr,
    output logic         tmr_run
);
    localparam logic [W-1:0] OC_LIM    = W'(OC_MS);
    localparam logic [W-1:0] SURGE_LIM = W'(SURGE_MS);
    localparam logic [W-1:0] QUAL_LIM  = W'(QUAL_MS);
    localparam logic [W-1:0] REC_LIM   = W'(REC_MS);

    mode_e nxt;
    logic  resume_soft;
    logic  qual;
    mode_e resume;

    assign qual   = f.brown | f.fb_high | f.ctl_high;
    assign resume = resume_soft ? M_SOFT : M_RUN;

    always_comb begin
        nxt = mode;
        if (!f.alive) begin
            nxt = M_BOOT;
        end else begin
            case (mode)
                M_BOOT: begin
                    if (f.on && !f.ctl_low) nxt = M_SOFT;
                end
                M_SOFT, M_RUN: begin
                    if (f.oc)                            nxt = M_HOLD_OC;
                    else if (f.surge)                    nxt = M_HOLD_SURGE;
                    else if (f.ctl_low)                  nxt = M_SLEEP_CTL;
                    else if (f.fb_low)                   nxt = M_HOLD_FB;
                    else if (mode == M_SOFT) begin
                        if (f.ss_end)                    nxt = M_RUN;
                    end else if (qual && (cnt >= QUAL_LIM)) begin
                        nxt = M_SLEEP_FLT;
                    end
                end
                M_HOLD_OC, M_HOLD_SURGE, M_HOLD_FB: begin
                    if (f.surge) begin
                        if (mode != M_HOLD_SURGE)        nxt = M_HOLD_SURGE;
                        else if (cnt >= SURGE_LIM)       nxt = M_SLEEP_FLT;
                    end else if (f.ctl_low) begin
                        nxt = M_SLEEP_CTL;
                    end else begin
                        case (mode)
                            M_HOLD_OC:    if (cnt >= OC_LIM) nxt = resume;
                            M_HOLD_FB:    if (!f.fb_low)     nxt = resume;
                            default:                         nxt = resume;
                        endcase
                    end
                end
                M_SLEEP_FLT: begin
                    if ((cnt >= REC_LIM) && !f.surge && !f.ctl_low) nxt = M_BOOT;
                end
                M_SLEEP_CTL: begin
                    if (!f.ctl_low && !f.surge) nxt = M_BOOT;
                end
                default: nxt = M_BOOT;
            endcase
        end
    end

    always_comb begin
        tmr_clr = (nxt != mode) || ((mode == M_RUN) && !qual);
        tmr_run = (mode == M_HOLD_OC) || (mode == M_HOLD_SURGE) ||
                  (mode == M_SLEEP_FLT) || ((mode == M_RUN) && qual);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= M_BOOT;
            resume_soft <= 1'b0;
        end else begin
            mode <= nxt;
            if (is_switching(mode) && is_hold(nxt)) begin
                resume_soft <= (mode == M_SOFT);
            end
        end
    end
endmodule

// File: rtl/seq_decode.sv
`timescale 1ns/1ps
module seq_decode
    import psu_seq_pkg::*;
(
    input  mode_e mode,
    input  logic  oc,
    output logic  sw_en,
    output logic  chg_en,
    output logic  ss_dis
);
    always_comb begin
        sw_en  = is_switching(mode) && !oc;
        chg_en = (mode == M_BOOT) || is_sleep(mode);
        ss_dis = is_sleep(mode);
    end
endmodule

// File: rtl/psu_mode_seq.sv
`timescale 1ns/1ps
module psu_mode_seq
    import psu_seq_pkg::*;
#(
    parameter int unsigned OC_MS    = 1,
    parameter int unsigned SURGE_MS = 10,
    parameter int unsigned QUAL_MS  = 100,
    parameter int unsigned REC_MS   = 2500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick_i,
    input  logic       vcc_alive_i,
    input  logic       vcc_on_i,
    input  logic       surge_i,
    input  logic       brown_i,
    input  logic       oc_i,
    input  logic       fb_high_i,
    input  logic       fb_low_i,
    input  logic       ctl_low_i,
    input  logic       ctl_high_i,
    input  logic       ss_end_i,
    output logic       sw_en_o,
    output logic       chg_en_o,
    output logic       ss_dis_o,
    output logic [2:0] mode_o
);
    localparam int unsigned T_MAX = max2(max2(OC_MS, SURGE_MS), max2(QUAL_MS, REC_MS));
    localparam int unsigned TW    = $clog2(T_MAX + 1);

    flags_t          flg;
    mode_e           mode;
    logic            tmr_clr;
    logic            tmr_run;
    logic [TW-1:0]   tmr_cnt;

    always_comb begin
        flg.alive    = vcc_alive_i;
        flg.on       = vcc_on_i;
        flg.surge    = surge_i;
        flg.brown    = brown_i;
        flg.oc       = oc_i;
        flg.fb_high  = fb_high_i;
        flg.fb_low   = fb_low_i;
        flg.ctl_low  = ctl_low_i;
        flg.ctl_high = ctl_high_i;
        flg.ss_end   = ss_end_i;
    end

    seq_timer #(.W(TW), .MAX(T_MAX)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .run  (tmr_run),
        .tick (ms_tick_i),
        .cnt  (tmr_cnt)
    );

    seq_fsm #(
        .W(TW), .OC_MS(OC_MS), .SURGE_MS(SURGE_MS),
        .QUAL_MS(QUAL_MS), .REC_MS(REC_MS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .f       (flg),
        .cnt     (tmr_cnt),
        .mode    (mode),
        .tmr_clr (tmr_clr),
        .tmr_run (tmr_run)
    );

    seq_decode u_dec (
        .mode   (mode),
        .oc     (oc_i),
        .sw_en  (sw_en_o),
        .chg_en (chg_en_o),
        .ss_dis (ss_dis_o)
    );

    assign mode_o = mode;
endmodule

// File: rtl/psu_mode_seq_chk.sv
`timescale 1ns/1ps
module psu_mode_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       vcc_alive_i,
    input logic       surge_i,
    input logic       oc_i,
    input logic       fb_low_i,
    input logic       ctl_low_i,
    input logic [2:0] mode_o
);
    logic swing;
    assign swing = (mode_o == 3'd1) || (mode_o == 3'd2);

    // R3
    supply_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !vcc_alive_i |=> mode_o == 3'd0);

    // R4
    oc_enter_chk: assert property (@(posedge clk) disable iff (rst)
        swing && vcc_alive_i && oc_i |=> mode_o == 3'd3);

    // R12
    surge_prio_chk: assert property (@(posedge clk) disable iff (rst)
        swing && vcc_alive_i && !oc_i && surge_i |=> mode_o == 3'd4);

    // R10
    ctl_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        swing && vcc_alive_i && !oc_i && !surge_i && ctl_low_i |=> mode_o == 3'd7);

    // R8
    soft_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        mode_o == 3'd1 && vcc_alive_i && !oc_i && !surge_i && !ctl_low_i && !fb_low_i
        |=> (mode_o == 3'd1) || (mode_o == 3'd2));

    // R6
    fb_release_chk: assert property (@(posedge clk) disable iff (rst)
        mode_o == 3'd5 && vcc_alive_i && !surge_i && !ctl_low_i && !fb_low_i
        |=> (mode_o == 3'd1) || (mode_o == 3'd2));
endmodule

bind psu_mode_seq psu_mode_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .vcc_alive_i (vcc_alive_i),
    .surge_i     (surge_i),
    .oc_i        (oc_i),
    .fb_low_i    (fb_low_i),
    .ctl_low_i   (ctl_low_i),
    .mode_o      (mode_o)
);

// File: tb/tb_psu_mode_seq.sv
`timescale 1ns/1ps
module tb_psu_mode_seq;
    localparam int OC_MS = 2, SURGE_MS = 4, QUAL_MS = 5, REC_MS = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 0, alive = 0, on = 0, surge = 0, brown = 0, oc = 0;
    logic fbh = 0, fbl = 0, cl = 0, ch = 0, sse = 0;
    logic sw, chg, dis;
    logic [2:0] mode;
    int vecs = 0, errs = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    psu_mode_seq #(.OC_MS(OC_MS), .SURGE_MS(SURGE_MS), .QUAL_MS(QUAL_MS), .REC_MS(REC_MS)) dut (
        .clk(clk), .rst(rst), .ms_tick_i(tick), .vcc_alive_i(alive), .vcc_on_i(on),
        .surge_i(surge), .brown_i(brown), .oc_i(oc), .fb_high_i(fbh), .fb_low_i(fbl),
        .ctl_low_i(cl), .ctl_high_i(ch), .ss_end_i(sse),
        .sw_en_o(sw), .chg_en_o(chg), .ss_dis_o(dis), .mode_o(mode)
    );

    task automatic chk(input string tag, input int got, input int exp);
        vecs++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
            tick = 1'b0;
        end
    endtask

    task automatic clear_flags();
        surge = 0; brown = 0; oc = 0; fbh = 0; fbl = 0; cl = 0; ch = 0; sse = 0; tick = 0;
    endtask

    task automatic outs(input string tag, input int s, input int c, input int d);
        chk({tag, " sw"}, int'(sw), s);
        chk({tag, " chg"}, int'(chg), c);
        chk({tag, " dis"}, int'(dis), d);
    endtask

    task automatic to_soft();
        rst = 1; clear_flags(); step();
        rst = 0; alive = 1; on = 1; step();
    endtask

    task automatic to_run();
        to_soft();
        sse = 1; step(); sse = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            vecs++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        @(negedge clk); step();
        // R1 reset state
        chk("R1 mode", mode, 0);
        outs("R1", 0, 1, 0);

        // R2 bring-up
        rst = 0; alive = 1; step();
        chk("R2 stays boot without on", mode, 0);
        on = 1; cl = 1; step();
        chk("R2 ctl low holds boot", mode, 0);
        cl = 0; step();
        chk("R2 soft", mode, 1);
        outs("R2 soft", 1, 0, 0);
        sse = 1; step(); sse = 0;
        chk("R2 run", mode, 2);
        outs("R11 run", 1, 0, 0);

        // R3 supply loss from run and from sleep
        alive = 0; step();
        chk("R3 run->boot", mode, 0);
        to_run(); cl = 1; step();
        chk("R10 sleep", mode, 7);
        outs("R11 ctl sleep", 0, 1, 1);
        alive = 0; step();
        chk("R3 sleep->boot", mode, 0);

        // R12 sweep from run and soft
        for (int v = 0; v < 32; v++) begin
            for (int s = 0; s < 2; s++) begin
                int exp;
                if (s == 0) to_run(); else to_soft();
                oc = v[0]; surge = v[1]; cl = v[2]; fbl = v[3]; brown = v[4];
                #1;
                chk("R4 sw cut", sw, v[0] ? 0 : 1);
                exp = v[0] ? 3 : v[1] ? 4 : v[2] ? 7 : v[3] ? 5 : (s == 0 ? 2 : 1);
                step();
                chk(s == 0 ? "R12 run prio" : "R8 R12 soft prio", mode, exp);
                clear_flags();
            end
        end

        // R4 overcurrent hold timing, R13 resume to run
        to_run(); oc = 1; step(); oc = 0;
        chk("R4 hold", mode, 3);
        outs("R11 hold", 0, 0, 0);
        ticks(OC_MS);
        chk("R4 still hold", mode, 3);
        step();
        chk("R13 resume run", mode, 2);

        // R13 resume to soft
        to_soft(); oc = 1; step(); oc = 0;
        ticks(OC_MS); step();
        chk("R13 resume soft", mode, 1);

        // R5 short surge
        to_run(); surge = 1; step();
        chk("R5 surge hold", mode, 4);
        ticks(SURGE_MS - 1);
        surge = 0; step();
        chk("R5 short resume", mode, 2);

        // R5 long surge, R9 surge holds sleep
        surge = 1; step();
        ticks(SURGE_MS);
        chk("R5 still hold", mode, 4);
        step();
        chk("R5 fault sleep", mode, 6);
        outs("R11 fault sleep", 0, 1, 1);
        ticks(REC_MS); step();
        chk("R9 surge holds sleep", mode, 6);
        surge = 0; step();
        chk("R9 restart", mode, 0);
        step();
        chk("R9 new soft", mode, 1);

        // R6 feedback hold
        to_run(); fbl = 1; step();
        chk("R6 hold", mode, 5);
        ticks(3);
        chk("R6 stays", mode, 5);
        fbl = 0; step();
        chk("R6 resume", mode, 2);

        // R7 qualification for each source
        for (int src = 0; src < 3; src++) begin
            to_run();
            brown = (src == 0); fbh = (src == 1); ch = (src == 2);
            ticks(3);
            brown = 0; fbh = 0; ch = 0; step();
            brown = (src == 0); fbh = (src == 1); ch = (src == 2);
            ticks(QUAL_MS - 1); step();
            chk("R7 restarted count", mode, 2);
            tick = 1; step(); tick = 0;
            chk("R7 just reached", mode, 2);
            step();
            chk("R7 fault sleep", mode, 6);
            brown = 0; fbh = 0; ch = 0;
            ticks(REC_MS - 1); step();
            chk("R9 early", mode, 6);
            ticks(1); step();
            chk("R9 recovered", mode, 0);
        end

        // R8 soft ignores slow faults for long
        to_soft(); brown = 1; fbh = 1; ch = 1;
        ticks(QUAL_MS + 3);
        chk("R8 soft kept", mode, 1);
        clear_flags();

        // R10 release control sleep
        to_run(); cl = 1; step();
        chk("R10 enter", mode, 7);
        surge = 1; cl = 0; step();
        chk("R10 surge blocks", mode, 7);
        surge = 0; step();
        chk("R10 release boot", mode, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule